// File: doc/BRIEF.md
# DMA/SCSI Interrupt Status Controller

This block gathers interrupt causes from a DMA engine and from an attached SCSI core into one status register. It drives a single registered interrupt line toward the host. The DMA engine reports three kinds of event: a transfer has finished, an address error occurred on the bus, and a page has completed during a descriptor-list transfer. A power-down pin adds a fourth cause on its first assertion. The SCSI core contributes a summary bit. Enable bits in a command register decide which of the DMA causes may reach the interrupt line.

The host reads the status register to find the source. That read clears every DMA-side flag. The SCSI summary bit behaves differently. It stays set until the SCSI core's three own status registers (status, internal state, interrupt status) have each been read. The core reports those reads through one strobe per register. An event that arrives in the same cycle as a clearing read is kept, so it is never lost.

Top module: `irqc_top`

## Requirements
- R1: After reset, the command register reads 0x00, the status register reads 0x00 and `irq_out` is low.
- R2: A write to address 0 stores all 8 bits of `reg_wdata` in the command register. A read of address 0 returns the stored value and has no side effect.
- R3: A one-cycle pulse on `ev_done`, `ev_addr_err` or `ev_page` sets status bit 0, 1 or 2. The bit becomes visible from the next cycle on, whatever the command register holds.
- R4: A read of address 1 returns the current status (bits 5 to 7 are zero). It then clears status bits 0 to 3 from the next cycle on.
- R5: A DMA-side event that occurs in the same cycle as a clearing status read leaves its bit set after the read. Other bits are still cleared.
- R6: A rising edge on `pwrdn_pin` sets status bit 3. Holding the pin high does not set the bit again after it has been cleared. A new low-to-high transition does set it again.
- R7: A rising edge on `scsi_irq` sets status bit 4. A status read does not clear bit 4.
- R8: Bit 4 clears once all three `scsi_rd_stb` bits have been seen while it is set, in any order or together. It stays set while any strobe is still missing. Strobes that arrive while bit 4 is clear are ignored.
- R9: `irq_out` is the registered OR of the status bits that are enabled, and it lags the status by one cycle. Bits 0 and 1 are enabled by command bit 6. Bit 2 is enabled by command bit 5. Bits 3 and 4 are always enabled.
- R10: Writes to address 1 do not change the status. Addresses 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 command, 1 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the read |
| ev_done | input | 1 | DMA transfer-complete pulse |
| ev_addr_err | input | 1 | DMA bus address error pulse |
| ev_page | input | 1 | DMA page-complete pulse |
| pwrdn_pin | input | 1 | Power-down pin level |
| scsi_irq | input | 1 | SCSI core interrupt level |
| scsi_rd_stb | input | 3 | SCSI core register read strobes (status, internal state, interrupt status) |
| irq_out | output | 1 | Interrupt output, active high |

## Verification
The hardest cases to reach are the races between an arriving cause and the clearing action. One is a DMA event that lands in the very cycle of a status read. The other is a SCSI summary bit whose last missing strobe arrives alongside a new rising edge. The bench drives the event pulse and the read strobe in the same cycle. It sweeps every subset of SCSI strobes in one cycle and every order of single strobes. It also crosses each cause with each combination of the two enable bits, so that the gating and the one-cycle latency of the output are covered everywhere.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int DATA_W   = 8;
  localparam int N_DMA    = 4;   // done, address error, page, power-down
  localparam int B_DONE   = 0;
  localparam int B_AERR   = 1;
  localparam int B_PAGE   = 2;
  localparam int B_PWR    = 3;
  localparam int B_SCSI   = 4;
  localparam int C_EN_XFR = 6;
  localparam int C_EN_PG  = 5;

  typedef enum logic [1:0] {
    A_CMD  = 2'd0,
    A_STAT = 2'd1
  } reg_sel_e;

  // Which status bits may drive the interrupt line for a given command value
  function automatic logic [DATA_W-1:0] enable_mask(input logic [DATA_W-1:0] cmd);
    logic [DATA_W-1:0] m;
    m         = '0;
    m[B_DONE] = cmd[C_EN_XFR];
    m[B_AERR] = cmd[C_EN_XFR];
    m[B_PAGE] = cmd[C_EN_PG];
    m[B_PWR]  = 1'b1;
    m[B_SCSI] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqc_rise.sv
`timescale 1ns/1ps
module irqc_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] pulse
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl[i];
    end
    assign pulse[i] = lvl[i] & ~prev;

    // R6: an edge pulse never lasts two cycles, so a held level cannot re-trigger
    p_single_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |=> !pulse[i]);
  end
endmodule

// File: rtl/irqc_dma_flags.sv
`timescale 1ns/1ps
module irqc_dma_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~{N{clr}}) | set;
  end

  // R4: a clearing read leaves only the bits set in that same cycle
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((flags & ~$past(set)) == '0));
  // R5: an event is never lost, even when it meets a clearing read
  p_event_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/irqc_scsi_track.sv
`timescale 1ns/1ps
module irqc_scsi_track #(
  parameter int NREG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise,
  input  logic [NREG-1:0] rd_stb,
  output logic            pending,
  output logic            all_seen
);
  logic [NREG-1:0] seen;
  logic [NREG-1:0] seen_nxt;

  assign seen_nxt = seen | rd_stb;
  assign all_seen = pending & (&seen_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      seen    <= '0;
    end else if (!pending || all_seen) begin
      pending <= rise;
      seen    <= '0;
    end else begin
      seen    <= seen_nxt;
    end
  end

  p_set_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pending);
  p_hold_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !all_seen) |=> pending);
  p_clear_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && all_seen && !rise) |=> !pending);
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top #(
  parameter int NREG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            ev_done,
  input  logic            ev_addr_err,
  input  logic            ev_page,
  input  logic            pwrdn_pin,
  input  logic            scsi_irq,
  input  logic [NREG-1:0] scsi_rd_stb,
  output logic            irq_out
);
  import irqc_pkg::*;

  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] status;
  logic [N_DMA-1:0]  dma_set;
  logic [N_DMA-1:0]  dma_flags;
  logic [1:0]        edges;      // [1] scsi, [0] power-down
  logic              stat_rd;
  logic              scsi_pend;
  logic              scsi_done;
  logic              pend_any;

  irqc_rise #(.W(2)) u_rise (
    .clk(clk), .rst_n(rst_n),
    .lvl({scsi_irq, pwrdn_pin}),
    .pulse(edges)
  );

  assign dma_set = {edges[0], ev_page, ev_addr_err, ev_done};
  assign stat_rd = reg_rd && (reg_addr == A_STAT);

  irqc_dma_flags #(.N(N_DMA)) u_dma (
    .clk(clk), .rst_n(rst_n),
    .set(dma_set), .clr(stat_rd),
    .flags(dma_flags)
  );

  irqc_scsi_track #(.NREG(NREG)) u_scsi (
    .clk(clk), .rst_n(rst_n),
    .rise(edges[1]), .rd_stb(scsi_rd_stb),
    .pending(scsi_pend), .all_seen(scsi_done)
  );

  always_comb begin
    status               = '0;
    status[N_DMA-1:0]    = dma_flags;
    status[B_SCSI]       = scsi_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cmd_q <= '0;
    else if (reg_wr && reg_addr == A_CMD)    cmd_q <= reg_wdata;
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = cmd_q;
      A_STAT:  reg_rdata = status;
      default: reg_rdata = '0;
    endcase
  end

  assign pend_any = |(status & enable_mask(cmd_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pend_any;
  end

  p_cmd_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CMD) |=> (cmd_q == $past(reg_wdata)));
  p_quiet_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> !irq_out);
  p_scsi_survives_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && scsi_pend && !scsi_done) |=> status[B_SCSI]);
endmodule

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ev_done = 1'b0, ev_addr_err = 1'b0, ev_page = 1'b0;
  logic       pwrdn_pin = 1'b0, scsi_irq = 1'b0;
  logic [2:0] scsi_rd_stb = 3'd0;
  logic       irq_out;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_done(ev_done), .ev_addr_err(ev_addr_err), .ev_page(ev_page),
    .pwrdn_pin(pwrdn_pin), .scsi_irq(scsi_irq), .scsi_rd_stb(scsi_rd_stb),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); v = reg_rdata;
    tick;
    reg_rd = 1'b0;
  endtask

  // pulse one cause: 0 done, 1 addr err, 2 page, 3 power-down, 4 scsi
  task automatic cause(input int k);
    case (k)
      0: ev_done = 1'b1;
      1: ev_addr_err = 1'b1;
      2: ev_page = 1'b1;
      3: pwrdn_pin = 1'b1;
      default: scsi_irq = 1'b1;
    endcase
    tick;
    ev_done = 1'b0; ev_addr_err = 1'b0; ev_page = 1'b0;
    pwrdn_pin = 1'b0; scsi_irq = 1'b0;
  endtask

  task automatic strobe(input logic [2:0] m);
    scsi_rd_stb = m;
    tick;
    scsi_rd_stb = 3'd0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] cmd;
    logic       exp_irq;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;

    // R1 reset state
    @(negedge clk); chk("R1 irq", irq_out, 0);
    tick;
    rd(2'd0, v); chk("R1 cmd", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);

    // R2 full sweep of command values with readback
    for (int i = 0; i < 256; i++) begin
      wr(2'd0, i[7:0]);
      rd(2'd0, v); chk("R2 cmd readback", v, i[7:0]);
    end
    wr(2'd0, 8'h00);
    while (irq_out) tick;

    // R3 + R4 each DMA cause, enable off
    for (int k = 0; k < 3; k++) begin
      cause(k);
      rd(2'd1, v); chk("R3 set bit", v, 32'(1) << k);
      rd(2'd1, v); chk("R4 cleared", v, 8'h00);
    end
    cause(0); cause(1); cause(2);
    rd(2'd1, v); chk("R4 all bits", v, 8'h07);
    rd(2'd1, v); chk("R4 all cleared", v, 8'h00);

    // R5 event meets clearing read
    cause(1);
    reg_addr = 2'd1; reg_rd = 1'b1; ev_done = 1'b1;
    @(negedge clk); chk("R5 pre-read value", reg_rdata, 8'h02);
    tick;
    reg_rd = 1'b0; ev_done = 1'b0;
    rd(2'd1, v); chk("R5 kept new event", v, 8'h01);
    rd(2'd1, v); chk("R5 then cleared", v, 8'h00);

    // R6 power-down edge, held level
    pwrdn_pin = 1'b1; tick;
    rd(2'd1, v); chk("R6 edge sets", v, 8'h08);
    repeat (4) tick;
    rd(2'd1, v); chk("R6 held level no retrigger", v, 8'h00);
    pwrdn_pin = 1'b0; tick;
    pwrdn_pin = 1'b1; tick;
    rd(2'd1, v); chk("R6 new edge sets", v, 8'h08);
    pwrdn_pin = 1'b0; tick;
    while (irq_out) tick;

    // R7 scsi bit survives status reads
    cause(4);
    rd(2'd1, v); chk("R7 scsi set", v, 8'h10);
    rd(2'd1, v); chk("R7 survives read", v, 8'h10);

    // R8 every order of single strobes
    strobe(3'b111);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          if (a != b && b != c && a != c) begin
            cause(4);
            strobe(3'(1 << a));
            rd(2'd1, v); chk("R8 first strobe holds", v, 8'h10);
            strobe(3'(1 << b));
            rd(2'd1, v); chk("R8 second strobe holds", v, 8'h10);
            strobe(3'(1 << c));
            rd(2'd1, v); chk("R8 third strobe clears", v, 8'h00);
          end

    // R8 every subset in one cycle
    for (int m = 0; m < 8; m++) begin
      cause(4);
      strobe(m[2:0]);
      rd(2'd1, v); chk("R8 subset", v, (m == 7) ? 8'h00 : 8'h10);
      strobe(3'b111);
    end

    // R8 strobes while clear are ignored
    strobe(3'b011);
    cause(4);
    strobe(3'b100);
    rd(2'd1, v); chk("R8 early strobes ignored", v, 8'h10);
    strobe(3'b011);
    rd(2'd1, v); chk("R8 clear after all", v, 8'h00);

    // R8 last strobe together with a new rising edge keeps the bit
    cause(4);
    strobe(3'b011);
    scsi_irq = 1'b1; scsi_rd_stb = 3'b100; tick;
    scsi_irq = 1'b0; scsi_rd_stb = 3'b000;
    rd(2'd1, v); chk("R8 new edge at clear", v, 8'h10);
    strobe(3'b111);
    while (irq_out) tick;

    // R9 gating sweep: enable combos x causes, with one-cycle latency
    for (int c = 0; c < 4; c++) begin
      cmd = {1'b0, c[1], c[0], 5'b0};
      wr(2'd0, cmd);
      for (int k = 0; k < 5; k++) begin
        exp_irq = (k < 2) ? c[1] : (k == 2) ? c[0] : 1'b1;
        cause(k);
        @(negedge clk); chk("R9 latency", irq_out, 0);
        tick;
        @(negedge clk); chk("R9 gated irq", irq_out, exp_irq);
        if (k == 4) strobe(3'b111); else rd(2'd1, v);
        tick; tick;
        @(negedge clk); chk("R9 irq drops", irq_out, 0);
        tick;
      end
    end
    wr(2'd0, 8'h00);

    // R10 status not writable, unused addresses read zero
    cause(2);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R10 write ignored", v, 8'h04);
    rd(2'd2, v); chk("R10 addr 2 zero", v, 8'h00);
    rd(2'd3, v); chk("R10 addr 3 zero", v, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R10 no set by write", v, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule